// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. Each entry holds a virtual page number, an address-space identifier, a physical frame number and two permission bits (writable, executable). A lookup compares the requested page number and identifier against every entry in parallel. The result (hit with frame number and permissions, miss, or protection fault) is returned combinationally in the same cycle. Because entries carry the identifier, translations of several processes can live side by side and a context switch needs no flush.

On a miss an external table walker, which is not part of this block, fetches the translation and presents it on the fill port. The block writes it on the next clock edge. If an entry with the same page number and identifier already exists, the fill overwrites that entry. Otherwise the lowest-numbered invalid entry is used. When no entry is free, a round-robin pointer picks a non-pinned victim. Pinned entries survive both replacement and flushes. A flush can clear every non-pinned entry, or only the non-pinned entries of one identifier.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: With `lk_valid` high, exactly one of `lk_hit`, `lk_miss`, `lk_fault` is high in the same cycle. A match needs both page number and identifier to agree. On a hit, `lk_pfn`, `lk_w` and `lk_x` show the stored frame and permissions. With `lk_valid` low, all three result outputs are low.
- R3: A fill presented in one cycle is visible to lookups from the next cycle on.
- R4: A lookup with `lk_write` high that matches an entry whose writable bit is 0 raises `lk_fault`, with `lk_hit` and `lk_miss` low.
- R5: A fill with no existing match goes to the lowest-indexed invalid entry when one exists. The round-robin pointer does not move.
- R6: When every entry is valid, a fill replaces the first non-pinned entry found scanning upward (with wrap) from the round-robin pointer. The pointer, which is 0 after reset, then moves to the entry after the victim.
- R7: When all entries are pinned and the fill matches none, the fill is dropped and the contents are unchanged.
- R8: A flush by identifier invalidates, in one cycle, every non-pinned entry carrying that identifier. All other entries are untouched.
- R9: A flush-all invalidates every non-pinned entry. Pinned entries stay valid.
- R10: A fill whose page number and identifier match a valid entry overwrites that entry, so no two valid entries ever match the same key.
- R11: When a flush and a fill occur in the same cycle, the flush is applied first and the fill is then placed using the post-flush contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Identifier of the current address space |
| lk_write | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Match found but write to a read-only page |
| lk_pfn | output | PFN_W | Frame number of the matching entry |
| lk_w | output | 1 | Writable bit of the matching entry |
| lk_x | output | 1 | Executable bit of the matching entry |
| fl_valid | input | 1 | Fill request from the walker |
| fl_vpn | input | VPN_W | Page number to install |
| fl_asid | input | ASID_W | Identifier to install |
| fl_pfn | input | PFN_W | Frame number to install |
| fl_w | input | 1 | Writable permission to install |
| fl_x | input | 1 | Executable permission to install |
| fl_pin | input | 1 | Install as pinned (never replaced or flushed) |
| fsh_asid_en | input | 1 | Flush non-pinned entries of one identifier |
| fsh_asid | input | ASID_W | Identifier to flush |
| fsh_all | input | 1 | Flush all non-pinned entries |

## Verification
On every cycle, the assertions check four properties. First, no two valid entries match one lookup key. Second, a lookup yields exactly one outcome. Third, a flush-all leaves only pinned entries valid. Fourth, a fill into a fully pinned buffer leaves the tags unchanged. Reset clearing all entries is checked as well. Several behaviours can only be shown by the bench's scenarios, because they depend on history. These are victim order (free entries first, then round-robin skipping pinned entries), overwrite of an existing tag, identifier-selective flushing, and a flush and fill in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // Where a fill lands
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_DUP   = 2'd1,
        SRC_FREE  = 2'd2,
        SRC_EVICT = 2'd3
    } fill_src_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 8,
    parameter int TAG_W = 28
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     pinned,
    input  logic [IDX_W-1:0] rr,
    output logic             free_ok,
    output logic [IDX_W-1:0] free_idx,
    output logic             evict_ok,
    output logic [IDX_W-1:0] evict_idx
);
    always_comb begin
        free_ok   = 1'b0;
        free_idx  = '0;
        evict_ok  = 1'b0;
        evict_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(rr) + k) % N;
            if (!pinned[j]) begin
                evict_ok  = 1'b1;
                evict_idx = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_w,
    output logic              lk_x,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic              fl_w,
    input  logic              fl_x,
    input  logic              fl_pin,
    input  logic              fsh_asid_en,
    input  logic [ASID_W-1:0] fsh_asid,
    input  logic              fsh_all
);
    import tlb_pkg::*;

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int TAG_W = VPN_W + ASID_W;

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0]            pin;
        logic [N-1:0]            pw;
        logic [N-1:0]            px;
        logic [N-1:0][TAG_W-1:0] tag;
        logic [N-1:0][PFN_W-1:0] pfn;
        logic [IDX_W-1:0]        rr;
    } state_t;

    state_t state_d, state_q;

    // ---------------- lookup ----------------
    logic [N-1:0]     lk_vec;
    logic             lk_any;
    logic [IDX_W-1:0] lk_idx;

    tlb_cam #(.N(N), .TAG_W(TAG_W)) u_lk_cam (
        .vld(state_q.vld), .tags(state_q.tag),
        .key({lk_vpn, lk_asid}), .hit_vec(lk_vec)
    );

    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_vec[i]) lk_idx = IDX_W'(i);
        end
        lk_any   = |lk_vec;
        lk_pfn   = state_q.pfn[lk_idx];
        lk_w     = state_q.pw[lk_idx];
        lk_x     = state_q.px[lk_idx];
        lk_fault = lk_valid && lk_any && lk_write && !state_q.pw[lk_idx];
        lk_hit   = lk_valid && lk_any && !lk_fault;
        lk_miss  = lk_valid && !lk_any;
    end

    // ---------------- flush then fill ----------------
    logic [N-1:0]     kill;
    logic [N-1:0]     vld_f;
    logic [N-1:0]     dup_vec;
    logic             dup_any;
    logic [IDX_W-1:0] dup_idx;
    logic             free_ok, evict_ok;
    logic [IDX_W-1:0] free_idx, evict_idx;
    fill_src_e        src;
    logic [IDX_W-1:0] tgt;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            kill[i] = !state_q.pin[i] &&
                      (fsh_all || (fsh_asid_en && state_q.tag[i][ASID_W-1:0] == fsh_asid));
        end
        vld_f = state_q.vld & ~kill;
    end

    tlb_cam #(.N(N), .TAG_W(TAG_W)) u_fl_cam (
        .vld(vld_f), .tags(state_q.tag),
        .key({fl_vpn, fl_asid}), .hit_vec(dup_vec)
    );

    tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .vld(vld_f), .pinned(state_q.pin), .rr(state_q.rr),
        .free_ok(free_ok), .free_idx(free_idx),
        .evict_ok(evict_ok), .evict_idx(evict_idx)
    );

    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (dup_vec[i]) dup_idx = IDX_W'(i);
        end
        dup_any = |dup_vec;

        src = SRC_NONE;
        tgt = '0;
        if (fl_valid) begin
            if (dup_any) begin
                src = SRC_DUP;   tgt = dup_idx;
            end else if (free_ok) begin
                src = SRC_FREE;  tgt = free_idx;
            end else if (evict_ok) begin
                src = SRC_EVICT; tgt = evict_idx;
            end
        end

        state_d     = state_q;
        state_d.vld = vld_f;
        if (src != SRC_NONE) begin
            state_d.vld[tgt] = 1'b1;
            state_d.pin[tgt] = fl_pin;
            state_d.pw[tgt]  = fl_w;
            state_d.px[tgt]  = fl_x;
            state_d.tag[tgt] = {fl_vpn, fl_asid};
            state_d.pfn[tgt] = fl_pfn;
        end
        if (src == SRC_EVICT) begin
            state_d.rr = (int'(tgt) == N - 1) ? '0 : tgt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // ---------------- assertions ----------------
    p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> (state_q.vld == '0))
        else $error("R1: entries valid after reset");

    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1))
        else $error("R2: lookup outcome not unique");

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault))
        else $error("R2: result without request");

    p_unique_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec))
        else $error("R10: duplicate matching entries");

    p_flush_all_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsh_all && !fl_valid) |=> (state_q.vld == state_q.pin))
        else $error("R9: flush-all left non-pinned or cleared pinned");

    p_full_pin_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && (&state_q.pin) && !dup_any) |=> $stable(state_q.tag))
        else $error("R7: fill altered fully pinned buffer");
endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0;
    logic [19:0] lk_vpn = 0;
    logic [7:0]  lk_asid = 0;
    logic        lk_hit, lk_miss, lk_fault, lk_w, lk_x;
    logic [15:0] lk_pfn;
    logic        fl_valid = 0, fl_w = 0, fl_x = 0, fl_pin = 0;
    logic [19:0] fl_vpn = 0;
    logic [7:0]  fl_asid = 0;
    logic [15:0] fl_pfn = 0;
    logic        fsh_asid_en = 0, fsh_all = 0;
    logic [7:0]  fsh_asid = 0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asid_tlb u0 (.*);

    // op: 0 lookup, 1 fill, 2 flush asid ; res: 1 hit, 2 miss, 3 fault
    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic [15:0] pfn;
        logic        w, x, wr;
        logic [1:0]  res;
        logic [7:0]  tag;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{2'd1, 20'h10, 8'd1, 16'h100, 1'b1, 1'b0, 1'b0, 2'd0, 8'd5},  // R5 fill entry0
        '{2'd0, 20'h10, 8'd1, 16'h100, 1'b1, 1'b0, 1'b0, 2'd1, 8'd3},  // R3 hit
        '{2'd0, 20'h10, 8'd2, 16'h000, 1'b0, 1'b0, 1'b0, 2'd2, 8'd2},  // R2 other asid
        '{2'd0, 20'h11, 8'd1, 16'h000, 1'b0, 1'b0, 1'b0, 2'd2, 8'd2},  // R2 other vpn
        '{2'd1, 20'h10, 8'd2, 16'h200, 1'b0, 1'b1, 1'b0, 2'd0, 8'd5},  // fill entry1 RO+X
        '{2'd0, 20'h10, 8'd2, 16'h200, 1'b0, 1'b1, 1'b1, 2'd3, 8'd4},  // R4 fault
        '{2'd0, 20'h10, 8'd2, 16'h200, 1'b0, 1'b1, 1'b0, 2'd1, 8'd2},  // R2 read hit
        '{2'd1, 20'h10, 8'd1, 16'h111, 1'b1, 1'b0, 1'b0, 2'd0, 8'd10}, // R10 overwrite
        '{2'd0, 20'h10, 8'd1, 16'h111, 1'b1, 1'b0, 1'b1, 2'd1, 8'd10}, // R10 new pfn
        '{2'd2, 20'h00, 8'd2, 16'h000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd8},  // flush asid 2
        '{2'd0, 20'h10, 8'd2, 16'h000, 1'b0, 1'b0, 1'b0, 2'd2, 8'd8},  // R8 gone
        '{2'd0, 20'h10, 8'd1, 16'h111, 1'b1, 1'b0, 1'b0, 2'd1, 8'd8}   // R8 kept
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // result code: 1 hit, 2 miss, 3 fault
    task automatic lookup(input logic [19:0] v, input logic [7:0] a, input logic wr,
                          input int exp_res, input logic [15:0] exp_pfn, input string req);
        int got;
        @(negedge clk);
        lk_valid = 1; lk_vpn = v; lk_asid = a; lk_write = wr;
        #1;
        got = lk_hit ? 1 : lk_miss ? 2 : lk_fault ? 3 : 0;
        check(got == exp_res, req, "outcome", got, exp_res);
        if (exp_res == 1) check(lk_pfn == exp_pfn, req, "pfn", lk_pfn, exp_pfn);
        lk_valid = 0; lk_write = 0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [15:0] p,
                        input logic w, input logic x, input logic pin);
        @(negedge clk);
        fl_valid = 1; fl_vpn = v; fl_asid = a; fl_pfn = p; fl_w = w; fl_x = x; fl_pin = pin;
        @(posedge clk);
        #1 fl_valid = 0;
    endtask

    task automatic flush(input logic all, input logic en, input logic [7:0] a);
        @(negedge clk);
        fsh_all = all; fsh_asid_en = en; fsh_asid = a;
        @(posedge clk);
        #1 fsh_all = 0; fsh_asid_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: lookup during and after reset misses
        lookup(20'h10, 8'd1, 1'b0, 2, 16'h0, "R1");
        @(negedge clk) rst_n = 1;
        lookup(20'h0, 8'd0, 1'b0, 2, 16'h0, "R1");
        // R2: idle request gives no outcome
        @(negedge clk); #1;
        check(!(lk_hit || lk_miss || lk_fault), "R2", "idle outcome",
              {lk_hit, lk_miss, lk_fault}, 0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", TBL[i].tag);
            case (TBL[i].op)
                2'd0: lookup(TBL[i].vpn, TBL[i].asid, TBL[i].wr, int'(TBL[i].res),
                             TBL[i].pfn, rq);
                2'd1: fill(TBL[i].vpn, TBL[i].asid, TBL[i].pfn, TBL[i].w, TBL[i].x, 1'b0);
                default: flush(1'b0, 1'b1, TBL[i].asid);
            endcase
        end

        // R2: permission outputs on hit (entry0 writable, not executable)
        @(negedge clk);
        lk_valid = 1; lk_vpn = 20'h10; lk_asid = 8'd1; #1;
        check(lk_w == 1 && lk_x == 0, "R2", "perm bits", {lk_w, lk_x}, 2'b10);
        lk_valid = 0;

        // R6: fill 8 entries, three pinned, then replace round-robin
        flush(1'b1, 1'b0, 8'd0);
        lookup(20'h10, 8'd1, 1'b0, 2, 16'h0, "R9");
        for (int i = 0; i < 8; i++)
            fill(20'h20 + 20'(i), 8'd3, 16'h300 + 16'(i), 1'b1, 1'b0, i < 3);
        fill(20'h30, 8'd3, 16'h330, 1'b1, 1'b0, 1'b0);          // victim 3
        lookup(20'h23, 8'd3, 1'b0, 2, 16'h0, "R6");
        lookup(20'h30, 8'd3, 1'b0, 1, 16'h330, "R6");
        fill(20'h31, 8'd3, 16'h331, 1'b1, 1'b0, 1'b0);          // victim 4
        lookup(20'h24, 8'd3, 1'b0, 2, 16'h0, "R6");
        lookup(20'h25, 8'd3, 1'b0, 1, 16'h305, "R6");
        lookup(20'h20, 8'd3, 1'b0, 1, 16'h300, "R6");

        // R8: flush asid keeps pinned
        flush(1'b0, 1'b1, 8'd3);
        lookup(20'h21, 8'd3, 1'b0, 1, 16'h301, "R8");
        lookup(20'h25, 8'd3, 1'b0, 2, 16'h0, "R8");

        // R9: flush all keeps pinned
        flush(1'b1, 1'b0, 8'd0);
        lookup(20'h22, 8'd3, 1'b0, 1, 16'h302, "R9");
        lookup(20'h31, 8'd3, 1'b0, 2, 16'h0, "R9");

        // R11: flush and fill in the same cycle
        fill(20'h61, 8'd4, 16'h461, 1'b1, 1'b0, 1'b0);          // entry3
        @(negedge clk);
        fsh_asid_en = 1; fsh_asid = 8'd4;
        fl_valid = 1; fl_vpn = 20'h60; fl_asid = 8'd4; fl_pfn = 16'h460;
        fl_w = 1; fl_x = 0; fl_pin = 0;
        @(posedge clk);
        #1 fsh_asid_en = 0; fl_valid = 0;
        lookup(20'h61, 8'd4, 1'b0, 2, 16'h0, "R11");
        lookup(20'h60, 8'd4, 1'b0, 1, 16'h460, "R11");

        // R7: pin everything, then a fill is dropped
        for (int i = 0; i < 5; i++)
            fill(20'h40 + 20'(i), 8'd5, 16'h540 + 16'(i), 1'b1, 1'b0, 1'b1);
        lookup(20'h60, 8'd4, 1'b0, 2, 16'h0, "R6");
        lookup(20'h44, 8'd5, 1'b0, 1, 16'h544, "R7");
        fill(20'h50, 8'd5, 16'h550, 1'b1, 1'b0, 1'b0);
        lookup(20'h50, 8'd5, 1'b0, 2, 16'h0, "R7");
        lookup(20'h40, 8'd5, 1'b0, 1, 16'h540, "R7");
        lookup(20'h20, 8'd3, 1'b0, 1, 16'h300, "R7");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule